// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects sixteen external interrupt request lines and presents the single most urgent one to a processor. Each line has its own trigger setting: it can follow the line's level with either polarity, or it can catch a falling or a rising edge in a latch that stays set until software clears it. Each line also has a three-bit urgency level. Level zero switches the line off completely.

A global threshold register sets a floor. A request is accepted only when its level is strictly above the threshold. Among the accepted requests, the highest level wins, and when two levels are equal the lower line number wins. The processor sees one interrupt output. It also sees a status word holding the winner's level and line number, together with a "nothing pending" flag that is active-low with respect to pending.

All settings are reached through a flat 32-bit register bus with byte addresses. Writes take effect at the clock edge and reads are combinational. Every external line passes through a two-flop synchronizer before any detection takes place.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable, trigger, level and threshold register reads 0. The output `cpu_irq` is 0 and the current-status word at 0xA0 reads 0x0001_0000.
- R2: Bit 0 of the register at 0x00 gates the controller. While it is 0, `cpu_irq` is 0 and status bit 16 reads 1, whatever the inputs are.
- R3: Trigger code 00 makes a line pending while its synchronized input is low. Code 01 makes it pending while the input is high. In both level codes, pending follows the input with no memory.
- R4: Trigger code 10 latches a falling edge and code 11 latches a rising edge. The latch stays set after the input returns to its former value.
- R5: A write to 0x60 with bit 8 set clears the edge latch of the line numbered in bits [3:0]. A write to 0x60 with bit 8 clear changes nothing.
- R6: Line n's level is held in bits [2:0] of the register at 0x10+4*(n/2) when n is even, and in bits [10:8] of that register when n is odd. A line whose level is 0 is never reported, even while it is pending.
- R7: A pending line is accepted only when its level is strictly greater than the threshold held in bits [2:0] at 0x40.
- R8: Among accepted lines, the highest level wins. Among lines of equal level, the lowest line number wins.
- R9: The status word at 0xA0 reads bit 16 = 0 while a request is accepted and 1 otherwise. Bits [10:8] hold the winner's level and bits [4:0] hold its line number. `cpu_irq` equals the inverse of bit 16.
- R10: Trigger codes for lines 0-7 sit at 0x04 and for lines 8-15 at 0x08, two bits per line at bits [2*(n%8)+1:2*(n%8)]. Each register reads back what was written.
- R11: The register at 0x80 reads the 16-bit vector of pending lines, before the level and threshold are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | External request lines, asynchronous |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A wrong edge latch can hold a request after it has been cleared, or drop a request before it is cleared. Either fault shows in the status word one cycle after the clearing write. The pending vector at 0x80 exposes the same fault for a line whose level hides it. A wrong arbitration or threshold compare shows as the wrong line number or level in the status word within three cycles of an input change, which is the synchronizer plus the edge stage. The vector table therefore covers overlapping sets of lines with tied and distinct levels, so that each compare path decides at least one winner.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N  = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [7:0]    bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          cpu_irq
);
  localparam int NMODE = N / 8;
  localparam int NLVL  = N / 2;
  localparam int IW    = $clog2(N);

  logic          en_q;
  logic [LW-1:0] mask_q;
  logic [1:0]    mode_q [N];
  logic [LW-1:0] lvl_q  [N];
  logic [N-1:0]  s1, s2, s3, edge_q, pend, acc, det;
  logic [LW-1:0] best_l;
  logic [IW-1:0] best_i;
  logic          hit;
  logic [31:0]   cur_status;

  wire scr_wr  = bus_we && bus_addr == 8'h60;
  wire scr_clr = scr_wr && bus_wdata[8];

  always_comb
    for (int i = 0; i < N; i++) begin
      det[i]  = mode_q[i][1] && (mode_q[i][0] ? (s2[i] && !s3[i]) : (!s2[i] && s3[i]));
      pend[i] = mode_q[i][1] ? edge_q[i] : (mode_q[i][0] ? s2[i] : !s2[i]);
      acc[i]  = en_q && pend[i] && (lvl_q[i] > mask_q);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
      edge_q <= '0;
      for (int i = 0; i < N; i++) begin
        mode_q[i] <= 2'b00;
        lvl_q[i]  <= '0;
      end
    end else begin
      s1 <= irq_in; s2 <= s1; s3 <= s2;
      for (int i = 0; i < N; i++)
        edge_q[i] <= (edge_q[i] || det[i]) &&
                     !(scr_clr && bus_wdata[3:0] == 4'(i));
      if (bus_we) begin
        if (bus_addr == 8'h00) en_q <= bus_wdata[0];
        if (bus_addr == 8'h40) mask_q <= bus_wdata[LW-1:0];
        for (int j = 0; j < NMODE; j++)
          if (bus_addr == 8'h04 + 8'(4*j))
            for (int b = 0; b < 8; b++) mode_q[8*j+b] <= bus_wdata[2*b +: 2];
        for (int k = 0; k < NLVL; k++)
          if (bus_addr == 8'h10 + 8'(4*k)) begin
            lvl_q[2*k]   <= bus_wdata[LW-1:0];
            lvl_q[2*k+1] <= bus_wdata[8 +: LW];
          end
      end
    end

  always_comb begin
    best_l = '0;
    best_i = '0;
    hit    = 1'b0;
    for (int i = N-1; i >= 0; i--)
      if (acc[i] && lvl_q[i] >= best_l) begin
        best_l = lvl_q[i];
        best_i = IW'(i);
        hit    = 1'b1;
      end
  end

  assign cur_status = {15'b0, !hit, 5'b0, best_l, 3'b0, 5'(best_i)};
  assign cpu_irq    = hit;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 8'h00) bus_rdata = {31'b0, en_q};
    if (bus_addr == 8'h40) bus_rdata = 32'(mask_q);
    if (bus_addr == 8'h80) bus_rdata = 32'(pend);
    if (bus_addr == 8'hA0) bus_rdata = cur_status;
    for (int j = 0; j < NMODE; j++)
      if (bus_addr == 8'h04 + 8'(4*j))
        for (int b = 0; b < 8; b++) bus_rdata[2*b +: 2] = mode_q[8*j+b];
    for (int k = 0; k < NLVL; k++)
      if (bus_addr == 8'h10 + 8'(4*k)) begin
        bus_rdata[LW-1:0] = lvl_q[2*k];
        bus_rdata[8 +: LW] = lvl_q[2*k+1];
      end
  end

  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !cpu_irq);

  p_scr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scr_clr |=> !edge_q[$past(bus_wdata[3:0])]);

  p_scr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_wr && !bus_wdata[8]) |=> (($past(edge_q) & ~edge_q) == '0));

  p_above_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (best_l > mask_q));

  p_level_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (best_l != '0));

  for (genvar g = 0; g < N; g++) begin : g_hold
    p_edge_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_q[g] && !scr_clr) |=> edge_q[g]);
  end
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [15:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (.clk, .rst_n, .irq_in, .bus_addr, .bus_we,
                    .bus_wdata, .bus_rdata, .cpu_irq);

  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0000, 32'h0001_0000}, {16'h0001, 32'h0000_0100},
    {16'h0003, 32'h0000_0201}, {16'h0018, 32'h0000_0403},
    {16'h0010, 32'h0000_0404}, {16'h0041, 32'h0000_0100},
    {16'h00A0, 32'h0000_0307}, {16'h00FF, 32'h0000_0403},
    {16'h0022, 32'h0000_0201}, {16'h0040, 32'h0000_0106}};

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    nchk++;
    if (bus_rdata !== exp) begin
      nfail++;
      $display("FAIL %s addr %h got %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic st_chk(input logic [31:0] exp, input string req);
    rd_chk(8'hA0, exp, req);
    nchk++;
    if (cpu_irq !== !exp[16]) begin
      nfail++;
      $display("FAIL R9 (%s) cpu_irq got %b expected %b", req, cpu_irq, !exp[16]);
    end
  endtask

  task automatic drive(input logic [15:0] v);
    @(negedge clk); irq_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    st_chk(32'h0001_0000, "R1");
    rd_chk(8'h04, 0, "R1");
    rd_chk(8'h10, 0, "R1");
    rd_chk(8'h00, 0, "R1");
    // setup: lines 0-7 active-high level, 8-15 rising edge
    wr(8'h04, 32'h5555); wr(8'h08, 32'hFFFF);
    wr(8'h10, 32'h0201); wr(8'h14, 32'h0403);
    wr(8'h18, 32'h0204); wr(8'h1C, 32'h0301);
    wr(8'h20, 32'h0505); wr(8'h24, 32'h0006);
    wr(8'h28, 32'h0007); wr(8'h2C, 32'h0000);
    // R10 / R6 readback
    rd_chk(8'h08, 32'hFFFF, "R10");
    rd_chk(8'h14, 32'h0403, "R6");
    // R2 gate still off
    drive(16'h0001);
    st_chk(32'h0001_0000, "R2");
    wr(8'h00, 1);
    // R3 R8 R9 table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][47:32]);
      st_chk(VEC[i][31:0], "R8");
    end
    // R7 threshold
    wr(8'h40, 2);
    drive(16'h0003); st_chk(32'h0001_0000, "R7");
    drive(16'h0007); st_chk(32'h0000_0302, "R7");
    wr(8'h40, 1);
    drive(16'h0003); st_chk(32'h0000_0201, "R7");
    wr(8'h40, 0);
    // R4 rising edge held, R5 clear
    drive(16'h0100); st_chk(32'h0000_0508, "R4");
    drive(16'h0000); st_chk(32'h0000_0508, "R4");
    wr(8'h60, 32'h0000_0008); st_chk(32'h0000_0508, "R5");
    wr(8'h60, 32'h0000_0108); st_chk(32'h0001_0000, "R5");
    // R4 falling edge on line 9
    wr(8'h08, 32'hFFFB);
    drive(16'h0200); st_chk(32'h0001_0000, "R4");
    drive(16'h0000); st_chk(32'h0000_0509, "R4");
    wr(8'h60, 32'h0000_0109); st_chk(32'h0001_0000, "R5");
    // R6 level 0 line 11, R11 pending vector
    drive(16'h0800); st_chk(32'h0001_0000, "R6");
    rd_chk(8'h80, 32'h0000_0800, "R11");
    wr(8'h60, 32'h0000_010B);
    rd_chk(8'h80, 32'h0000_0000, "R11");
    drive(16'h0000);
    // R3 active-low on line 0
    wr(8'h04, 32'h5554);
    drive(16'h0000); st_chk(32'h0000_0100, "R3");
    drive(16'h0001); st_chk(32'h0001_0000, "R3");
    drive(16'h0000);
    // R2 disable
    wr(8'h00, 0); st_chk(32'h0001_0000, "R2");
    wr(8'h00, 1); st_chk(32'h0000_0100, "R2");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule